// File: doc/BRIEF.md
# Daisy-Chained Periodic Interrupt Timer

This peripheral raises an interrupt request on a shared, open request line each time a fixed number of clock cycles has passed. The request stays up until a processor acknowledges it. Acknowledges travel along a chain of devices. A device that holds a request takes the acknowledge for itself and, in the next cycle, puts its identifier on a shared 32-bit data bus. A device with nothing pending passes the acknowledge on to the next device in the chain. Both the request line and the data bus are left at high impedance when this device has nothing to drive, so several devices can share them.

Inside, an interval counter produces a one-cycle expiry strobe. A three-state machine tracks the request: `ST_IDLE`, `ST_PENDING` and `ST_SERVE`. Its transitions are:

- `T_EXPIRE`: from idle to pending on an expiry.
- `T_ACK`: from pending to serve on an acknowledge.
- `T_RELEASE`: from serve to idle.
- `T_REARM`: from serve straight to pending, when an expiry lands in the serve cycle.
- `T_HOLD`: pending stays pending with no acknowledge. An expiry in that state merges into the request already held.

The interval (`INTERVAL`, default 2000) and the identifier (`DEVICE_ID`, default 0x1) are parameters.

Top module: `periodic_irq_timer`

## Requirements
- R1: A synchronous reset returns the counter and the request state to idle. After reset the request line is not driven high, the data bus does not carry `DEVICE_ID`, and `inta_out` is low while `inta_in` is low.
- R2: After reset is released, the first expiry raises the request line `INTERVAL` clock edges later. Each further expiry follows `INTERVAL` edges after the previous one.
- R3: While a request is pending, `int_line` is driven to 1. It stays at 1 for as long as no acknowledge arrives.
- R4: If `inta_in` is 1 while a request is pending, then after the next clock edge `int_line` is released and `data_bus` carries `DEVICE_ID` for exactly one cycle. The bus is released after that cycle.
- R5: If `inta_in` is 1 while no request is pending (this includes the serve cycle), `inta_out` is 1 in the same cycle.
- R6: In a cycle where this device takes the acknowledge (request pending and `inta_in` at 1), `inta_out` is 0.
- R7: The interval counter restarts as soon as it expires, whatever the state of service, so the request timing stays on multiples of `INTERVAL`. An expiry while a request is pending, including one on the same edge as the acknowledge, merges into that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inta_in | input | 1 | Acknowledge arriving from the processor or from the previous device |
| int_line | output | 1 | Shared request line: 1 while pending, otherwise high impedance |
| inta_out | output | 1 | Acknowledge passed on to the next device |
| data_bus | output | DATA_W | Shared data bus: `DEVICE_ID` in the serve cycle, otherwise high impedance |

## Verification
The assertions assume that `inta_in` is a clean level that changes only between clock edges. They also assume that reset is high at the first clock edge, since the reset property has no disable and looks at that edge. The bench drives `inta_in` and `rst` only at falling edges and holds reset from time zero. It acknowledges early, late (after several intervals have merged), in the serve cycle, and while idle. It also applies a reset in the middle of a run while a request is pending.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PENDING = 2'd1,
        ST_SERVE   = 2'd2
    } pit_state_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pit_interval_counter.sv
module pit_interval_counter #(
    parameter int unsigned INTERVAL = 2000
) (
    input  logic clk,
    input  logic rst,
    output logic expire
);
    localparam int unsigned CW = pit_pkg::cnt_width(INTERVAL);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    // Free-running: restarts on expiry regardless of service state.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expire = (cnt_q == LAST);

endmodule

// File: rtl/pit_request_fsm.sv
module pit_request_fsm
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic inta_in,
    output logic req_drive,
    output logic id_drive,
    output logic pass_ack,
    output logic pending,
    output logic serving
);
    pit_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (expire) state_d = ST_PENDING;           // T_EXPIRE
            end
            ST_PENDING: begin
                if (inta_in) state_d = ST_SERVE;            // T_ACK (expiry merged)
                else         state_d = ST_PENDING;          // T_HOLD
            end
            ST_SERVE: begin
                if (expire) state_d = ST_PENDING;           // T_REARM
                else        state_d = ST_IDLE;              // T_RELEASE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_drive = 1'b0;
        id_drive  = 1'b0;
        pass_ack  = inta_in;
        unique case (state_q)
            ST_IDLE: begin
                pass_ack = inta_in;
            end
            ST_PENDING: begin
                req_drive = 1'b1;
                pass_ack  = 1'b0;
            end
            ST_SERVE: begin
                id_drive = 1'b1;
                pass_ack = inta_in;
            end
            default: begin
                pass_ack = inta_in;
            end
        endcase
    end

    assign pending = (state_q == ST_PENDING);
    assign serving = (state_q == ST_SERVE);

endmodule

// File: rtl/pit_bus_drive.sv
module pit_bus_drive #(
    parameter int unsigned DATA_W    = 32,
    parameter logic [DATA_W-1:0] DEVICE_ID = DATA_W'(1)
) (
    input  logic              req_drive,
    input  logic              id_drive,
    output logic              int_line,
    output logic [DATA_W-1:0] data_bus
);
    // Request line is only ever pulled high, never low.
    assign int_line = req_drive ? 1'b1 : 1'bz;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign data_bus[b] = id_drive ? DEVICE_ID[b] : 1'bz;
    end

endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
    parameter int unsigned INTERVAL  = 2000,
    parameter int unsigned DATA_W    = 32,
    parameter logic [DATA_W-1:0] DEVICE_ID = DATA_W'(1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inta_in,
    output logic              int_line,
    output logic              inta_out,
    output logic [DATA_W-1:0] data_bus
);
    logic tick_w;
    logic req_drive_w;
    logic id_drive_w;
    logic pend_w;
    logic serve_w;

    pit_interval_counter #(.INTERVAL(INTERVAL)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .expire (tick_w)
    );

    pit_request_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .expire    (tick_w),
        .inta_in   (inta_in),
        .req_drive (req_drive_w),
        .id_drive  (id_drive_w),
        .pass_ack  (inta_out),
        .pending   (pend_w),
        .serving   (serve_w)
    );

    pit_bus_drive #(.DATA_W(DATA_W), .DEVICE_ID(DEVICE_ID)) u_bus (
        .req_drive (req_drive_w),
        .id_drive  (id_drive_w),
        .int_line  (int_line),
        .data_bus  (data_bus)
    );

endmodule

// File: rtl/pit_checker.sv
module pit_checker (
    input logic clk,
    input logic rst,
    input logic inta_in,
    input logic inta_out,
    input logic tick,
    input logic pending,
    input logic serving
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!pending && !serving)); // R1
    AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (rst)
        (tick && !pending) |=> pending); // R2
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (pending && !inta_in) |=> pending); // R3
    AST_ACK_SERVES: assert property (@(posedge clk) disable iff (rst)
        (pending && inta_in) |=> (serving && !pending)); // R4
    AST_SERVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        serving |=> !serving); // R4
    AST_PASS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (inta_in && !pending) |-> inta_out); // R5
    AST_CONSUME_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        pending |-> !inta_out); // R6
    AST_MERGE: assert property (@(posedge clk) disable iff (rst)
        (pending && tick && !inta_in) |=> (pending && $stable(pending))); // R7
    AST_STATE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pending && serving)); // R4
endmodule

bind periodic_irq_timer pit_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .inta_in  (inta_in),
    .inta_out (inta_out),
    .tick     (tick_w),
    .pending  (pend_w),
    .serving  (serve_w)
);

// File: tb/sim_periodic_irq_timer.sv
`timescale 1ns/1ps
module sim_periodic_irq_timer;
    localparam int unsigned IVL = 12;
    localparam int unsigned DW  = 32;
    localparam logic [DW-1:0] ID = 32'h0000_00A5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inta_in = 1'b0;
    wire  int_line;
    wire  inta_out;
    wire  [DW-1:0] data_bus;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // scoreboard queues: {exp_int, exp_data, exp_out}
    bit [2:0] exp_q[$];
    string    tag_q[$];

    // requirement-level model state
    int m_n = 0;
    bit m_pend = 1'b0;
    bit m_serve = 1'b0;

    always #4 clk = ~clk;

    periodic_irq_timer #(.INTERVAL(IVL), .DATA_W(DW), .DEVICE_ID(ID)) u0 (
        .clk      (clk),
        .rst      (rst),
        .inta_in  (inta_in),
        .int_line (int_line),
        .inta_out (inta_out),
        .data_bus (data_bus)
    );

    task automatic step(input bit r, input bit a, input string tag);
        bit expire;
        @(negedge clk);
        rst = r;
        inta_in = a;
        exp_q.push_back({m_pend, m_serve, a & ~m_pend});
        tag_q.push_back(tag);
        if (r) begin
            m_n = 0; m_pend = 0; m_serve = 0;
        end else begin
            expire = (((m_n + 1) % IVL) == 0);
            m_n++;
            if (m_pend && a) begin
                m_pend = 0; m_serve = 1;
            end else if (!m_pend) begin
                m_serve = 0; m_pend = expire;
            end
        end
    endtask

    task automatic run(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) step(1'b0, 1'b0, tag);
    endtask

    task automatic wait_pending_then_ack(input string tag);
        while (!m_pend) step(1'b0, 1'b0, tag);
        step(1'b0, 1'b1, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit [2:0] e;
                string t;
                bit got_int, got_data;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got_int  = (int_line === 1'b1);
                got_data = (data_bus === ID);
                n_checks++;
                if (got_int !== e[2] || got_data !== e[1] || inta_out !== e[0]) begin
                    n_fail++;
                    $display("FAIL %s: int=%0b data_is_id=%0b inta_out=%0b expected int=%0b data_is_id=%0b inta_out=%0b",
                             t, got_int, got_data, inta_out, e[2], e[1], e[0]);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired, expected run to finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with and without acknowledge during reset
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b0, "R1");
        // R5: acknowledge while idle passes down the chain
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, "R5");
        // R2: first expiry after INTERVAL edges
        run(IVL + 2, "R2");
        // R3/R6: held while not acknowledged, then consumed
        run(3, "R3");
        step(1'b0, 1'b1, "R6");
        // R4/R5: serve cycle, acknowledge during serve passes down
        step(1'b0, 1'b1, "R4");
        run(2, "R4");
        // R2/R7: next expiry stays on the grid
        wait_pending_then_ack("R7");
        run(1, "R4");
        // R7: late service, several expiries merged
        wait_pending_then_ack("R2");
        step(1'b0, 1'b0, "R4");
        while (!m_pend) step(1'b0, 1'b0, "R2");
        run(3 * IVL, "R7");
        step(1'b0, 1'b1, "R6");
        run(2 * IVL, "R7");
        // R7: acknowledge on the expiry edge
        while ((m_n % IVL) != IVL - 1 || !m_pend) step(1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, "R7");
        run(IVL + 3, "R7");
        // R1: mid-run reset while pending
        while (!m_pend) step(1'b0, 1'b0, "R3");
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, "R5");
        run(IVL + 2, "R2");
        step(1'b0, 1'b1, "R6");
        run(2, "R4");
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule